// File: doc/BRIEF.md
# Card Register Window Decoder with Lane Swap

This block sits between a big-endian host bus and two 16-bit peripherals on an expansion card: an Ethernet controller and an auxiliary module. It takes a card-relative 16-bit offset, the access size (byte or word), the direction and the write data. From these it produces a peripheral register index, one chip select per peripheral, a lane-swap enable, a wait-state count and the read data returned to the host. Each result is registered, so it appears one clock after the request.

Controller registers sit 4 bytes apart. The controller can be reached through two aliased windows that differ in one respect only. One window exchanges the two bytes of every 16-bit transfer, so that little-endian data reads correctly on the big-endian host. The other window passes the data through unchanged. The auxiliary module has the same pair of windows. The card's own interrupt status register needs no chip select. It is mirrored at every offset that fits a sparse bit pattern, and a byte access to it can see the interrupt flag. All other offsets are reserved and select nothing.

The peripheral's read data (`per_rdata`) is sampled in the same cycle as the request. It is returned on `rdata` in the following cycle, swapped if the window calls for it.

Top module: `rwin_decoder`

## Requirements
- R1: A word read whose offset has bit 15 = 0, bit 11 = 0 and bits [6:0] = 7'h40 (for example 0x0040 or 0x7740) returns `rdata` = {eth_irq, 15'b0} one cycle later, with both chip selects low.
- R2: A byte read of an offset matching the R1 pattern returns `rdata` with bit 7 = eth_irq and every other bit 0.
- R3: A write to an offset matching the R1 pattern has no effect: `rsp_valid` is 1, both chip selects are low, and `rdata`, `per_wdata`, `reg_idx`, `wait_cnt` and `swap_en` are 0.
- R4: A word access in 0x0800–0x0FFF with offset bit 7 = 0 asserts `cs_eth` with `swap_en` = 1, `reg_idx` = offset[6:2] and `wait_cnt` = REG_WAIT (default 1).
- R5: A word access to the controller windows with offset bit 7 = 1 (for example 0x0880–0x08FC, or its mirrors up to 0x0FFC) targets the data port: `reg_idx` = DATA_IDX (default 16) and `wait_cnt` = 0.
- R6: A word access in 0x1800–0x1FFF behaves as R4 and R5 with the same index and wait rules, except that `swap_en` = 0.
- R7: A word access in 0x2800–0x2FFF asserts `cs_aux` with `swap_en` = 1. One in 0x3800–0x3FFF asserts `cs_aux` with `swap_en` = 0. In both cases `reg_idx` = offset[6:2] and `wait_cnt` = AUX_WAIT (default 1).
- R8: A byte access inside any peripheral window asserts no chip select, and leaves `rdata` and `per_wdata` at 0.
- R9: An offset that is neither in a peripheral window nor a status mirror (for example 0x0000, 0x1000, 0x4800, 0x8000, 0xC040) asserts no chip select and returns 0 on all data, index and wait outputs.
- R10: When a chip select is active and `swap_en` = 1, `per_wdata` = {wdata[7:0], wdata[15:8]} on writes and `rdata` = {per_rdata[7:0], per_rdata[15:8]} on reads. When `swap_en` = 0, both paths pass the data unchanged. The unused data path is 0.
- R11: Every output is registered. `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and with no request every output is 0.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_addr | input | 16 | Card-relative byte offset |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Host write data |
| eth_irq | input | 1 | Ethernet controller interrupt line, active high |
| per_rdata | input | 16 | Read data from the addressed peripheral, valid in the request cycle |
| rsp_valid | output | 1 | Decode result valid |
| cs_eth | output | 1 | Ethernet controller chip select |
| cs_aux | output | 1 | Auxiliary module chip select |
| swap_en | output | 1 | Byte lanes exchanged for this access |
| reg_idx | output | 5 | Peripheral register index |
| wait_cnt | output | 2 | Wait states for this access |
| per_wdata | output | 16 | Write data to the peripheral |
| rdata | output | 16 | Read data to the host |

## Verification
The assertions assume the following about the inputs:
- `req_valid` and the request fields are synchronous and stable around the clock edge.
- `per_rdata` and `eth_irq` are valid in the cycle of the request.
- The properties that use `$past` look back only at the cycle before the result.

The bench meets these assumptions by changing every input on the falling edge only. It gives `per_rdata` a fresh value for every request, so that the unswapped and swapped paths can be told apart. It also toggles `eth_irq` between status reads, so that a fixed bit cannot pass the status checks.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned WAIT_W = 2;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_STATUS = 2'd1,
        WIN_ETH    = 2'd2,
        WIN_AUX    = 2'd3
    } win_kind_e;

    typedef struct packed {
        win_kind_e         kind;
        logic              swap;
        logic              data_port;
        logic [IDX_W-1:0]  idx;
    } win_dec_t;

    typedef struct packed {
        logic              rsp_valid;
        logic              cs_eth;
        logic              cs_aux;
        logic              swap_en;
        logic [IDX_W-1:0]  reg_idx;
        logic [WAIT_W-1:0] wait_cnt;
        logic [DATA_W-1:0] per_wdata;
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;

endpackage

// File: rtl/rwin_classify.sv
module rwin_classify
    import rwin_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_word,
    output win_dec_t          dec
);
    logic status_hit;
    logic periph_hit;
    logic unused_bits;

    // Status mirror pattern: bit15=0, bit11=0, low seven bits = 7'h40
    assign status_hit = (addr[15] == 1'b0) && (addr[11] == 1'b0) &&
                        (addr[6:0] == 7'h40);

    // Peripheral windows: top two bits zero and bit 11 set.
    // bit13 picks the module, bit12 set means straight (no swap).
    assign periph_hit = (addr[15:14] == 2'b00) && addr[11] && is_word;

    assign unused_bits = ^addr[10:8];

    always_comb begin
        dec           = '0;
        dec.kind      = WIN_NONE;
        if (status_hit) begin
            dec.kind = WIN_STATUS;
        end else if (periph_hit) begin
            dec.kind      = addr[13] ? WIN_AUX : WIN_ETH;
            dec.swap      = ~addr[12];
            dec.data_port = ~addr[13] & addr[7];
            dec.idx       = addr[6:2];
        end
    end

    always_comb begin
        assert (!(status_hit && periph_hit))
            else $error("p_windows_disjoint_r9: status and peripheral overlap");
    end
endmodule

// File: rtl/rwin_lane_swap.sv
module rwin_lane_swap
    import rwin_pkg::*;
(
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] swapped;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign swapped[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    end

    assign dout = en ? swapped : din;
endmodule

// File: rtl/rwin_status_fmt.sv
module rwin_status_fmt
    import rwin_pkg::*;
(
    input  logic              irq,
    input  logic              is_word,
    output logic [DATA_W-1:0] val
);
    localparam int unsigned WORD_BIT = DATA_W - 1;
    localparam int unsigned BYTE_BIT = LANE_W - 1;

    always_comb begin
        val = '0;
        if (is_word) begin
            val[WORD_BIT] = irq;
        end else begin
            val[BYTE_BIT] = irq;
        end
    end
endmodule

// File: rtl/rwin_decoder.sv
module rwin_decoder
    import rwin_pkg::*;
#(
    parameter int unsigned REG_WAIT   = 1,
    parameter int unsigned DPORT_WAIT = 0,
    parameter int unsigned AUX_WAIT   = 1,
    parameter int unsigned DATA_IDX   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [15:0]       req_addr,
    input  logic              req_word,
    input  logic              req_wr,
    input  logic [15:0]       req_wdata,
    input  logic              eth_irq,
    input  logic [15:0]       per_rdata,
    output logic              rsp_valid,
    output logic              cs_eth,
    output logic              cs_aux,
    output logic              swap_en,
    output logic [4:0]        reg_idx,
    output logic [1:0]        wait_cnt,
    output logic [15:0]       per_wdata,
    output logic [15:0]       rdata
);
    localparam logic [WAIT_W-1:0] REG_WAIT_V   = WAIT_W'(REG_WAIT);
    localparam logic [WAIT_W-1:0] DPORT_WAIT_V = WAIT_W'(DPORT_WAIT);
    localparam logic [WAIT_W-1:0] AUX_WAIT_V   = WAIT_W'(AUX_WAIT);
    localparam logic [IDX_W-1:0]  DATA_IDX_V   = IDX_W'(DATA_IDX);

    win_dec_t          dec;
    logic [DATA_W-1:0] status_val;
    logic [DATA_W-1:0] wdata_lane;
    logic [DATA_W-1:0] rdata_lane;
    rsp_state_t        st_d;
    rsp_state_t        st_q;

    rwin_classify u_classify (
        .addr    (req_addr),
        .is_word (req_word),
        .dec     (dec)
    );

    rwin_status_fmt u_status (
        .irq     (eth_irq),
        .is_word (req_word),
        .val     (status_val)
    );

    rwin_lane_swap u_wswap (
        .en   (dec.swap),
        .din  (req_wdata),
        .dout (wdata_lane)
    );

    rwin_lane_swap u_rswap (
        .en   (dec.swap),
        .din  (per_rdata),
        .dout (rdata_lane)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.rsp_valid = 1'b1;
            unique case (dec.kind)
                WIN_STATUS: begin
                    if (!req_wr) begin
                        st_d.rdata = status_val;
                    end
                end
                WIN_ETH, WIN_AUX: begin
                    st_d.cs_eth  = (dec.kind == WIN_ETH);
                    st_d.cs_aux  = (dec.kind == WIN_AUX);
                    st_d.swap_en = dec.swap;
                    if (dec.kind == WIN_AUX) begin
                        st_d.reg_idx  = dec.idx;
                        st_d.wait_cnt = AUX_WAIT_V;
                    end else if (dec.data_port) begin
                        st_d.reg_idx  = DATA_IDX_V;
                        st_d.wait_cnt = DPORT_WAIT_V;
                    end else begin
                        st_d.reg_idx  = dec.idx;
                        st_d.wait_cnt = REG_WAIT_V;
                    end
                    if (req_wr) begin
                        st_d.per_wdata = wdata_lane;
                    end else begin
                        st_d.rdata = rdata_lane;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign cs_eth    = st_q.cs_eth;
    assign cs_aux    = st_q.cs_aux;
    assign swap_en   = st_q.swap_en;
    assign reg_idx   = st_q.reg_idx;
    assign wait_cnt  = st_q.wait_cnt;
    assign per_wdata = st_q.per_wdata;
    assign rdata     = st_q.rdata;

    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !cs_eth && !cs_aux && rdata == '0));

    p_one_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_eth, cs_aux}));

    p_byte_no_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_word) |=> (!cs_eth && !cs_aux));

    p_status_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wr && !req_addr[15] && !req_addr[11] &&
         req_addr[6:0] == 7'h40) |=> (!cs_eth && !cs_aux && rdata == '0));

    p_status_word_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && !req_wr && !req_addr[15] && !req_addr[11] &&
         req_addr[6:0] == 7'h40) |=> (rdata == {$past(eth_irq), 15'b0}));

    p_dataport_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && req_addr[15:11] == 5'b00001 && req_addr[7])
        |=> (cs_eth && wait_cnt == DPORT_WAIT_V && reg_idx == DATA_IDX_V));

    p_swap_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && req_wr && req_addr[15:14] == 2'b00 &&
         req_addr[11] && !req_addr[12])
        |=> (swap_en && per_wdata == {$past(req_wdata[7:0]), $past(req_wdata[15:8])}));

    p_straight_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && !req_wr && req_addr[15:11] == 5'b00011)
        |=> (cs_eth && !swap_en && rdata == $past(per_rdata)));
endmodule

// File: tb/rwin_decoder_tb.sv
module rwin_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        eth_irq = 1'b0;
    logic [15:0] per_rdata = '0;
    logic        rsp_valid, cs_eth, cs_aux, swap_en;
    logic [4:0]  reg_idx;
    logic [1:0]  wait_cnt;
    logic [15:0] per_wdata, rdata;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // expected values for the current cycle
    bit          e_rsp, e_ce, e_ca, e_sw;
    int          e_idx, e_wait;
    logic [15:0] e_pw, e_rd;
    string       e_tag = "R12";
    string       e_dtag = "R12";

    always #5 clk = ~clk;

    rwin_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_wr(req_wr), .req_wdata(req_wdata),
        .eth_irq(eth_irq), .per_rdata(per_rdata), .rsp_valid(rsp_valid),
        .cs_eth(cs_eth), .cs_aux(cs_aux), .swap_en(swap_en), .reg_idx(reg_idx),
        .wait_cnt(wait_cnt), .per_wdata(per_wdata), .rdata(rdata)
    );

    function automatic logic [15:0] bswap(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    // Behavioural reference: evaluated on every rising edge
    always @(posedge clk or negedge rst_n) begin
        int a;
        bit sw, port;
        e_rsp = 0; e_ce = 0; e_ca = 0; e_sw = 0;
        e_idx = 0; e_wait = 0; e_pw = '0; e_rd = '0;
        e_tag = "R11"; e_dtag = "R11";
        if (!rst_n) begin
            e_tag = "R12"; e_dtag = "R12";
        end else if (req_valid) begin
            a = int'(req_addr);
            e_rsp = 1;
            if ((a & 'h887F) == 'h0040) begin
                e_tag = req_wr ? "R3" : (req_word ? "R1" : "R2");
                e_dtag = e_tag;
                if (!req_wr) e_rd = req_word ? {eth_irq, 15'b0} : {8'b0, eth_irq, 7'b0};
            end else if ((a >= 'h0800 && a < 'h1000) || (a >= 'h1800 && a < 'h2000)) begin
                sw = (a < 'h1000);
                if (!req_word) begin
                    e_tag = "R8"; e_dtag = "R8";
                end else begin
                    port = ((a / 128) % 2) == 1;
                    e_ce = 1; e_sw = sw;
                    e_idx = port ? 16 : (a / 4) % 32;
                    e_wait = port ? 0 : 1;
                    e_tag = port ? "R5" : (sw ? "R4" : "R6");
                    e_dtag = "R10";
                    if (req_wr) e_pw = sw ? bswap(req_wdata) : req_wdata;
                    else        e_rd = sw ? bswap(per_rdata) : per_rdata;
                end
            end else if ((a >= 'h2800 && a < 'h3000) || (a >= 'h3800 && a < 'h4000)) begin
                sw = (a < 'h3000);
                if (!req_word) begin
                    e_tag = "R8"; e_dtag = "R8";
                end else begin
                    e_ca = 1; e_sw = sw;
                    e_idx = (a / 4) % 32;
                    e_wait = 1;
                    e_tag = "R7"; e_dtag = "R10";
                    if (req_wr) e_pw = sw ? bswap(req_wdata) : req_wdata;
                    else        e_rd = sw ? bswap(per_rdata) : per_rdata;
                end
            end else begin
                e_tag = "R9"; e_dtag = "R9";
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h addr_prev t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk(e_tag, "rsp_valid", int'(rsp_valid), int'(e_rsp));
            chk(e_tag, "cs_eth", int'(cs_eth), int'(e_ce));
            chk(e_tag, "cs_aux", int'(cs_aux), int'(e_ca));
            chk(e_tag, "swap_en", int'(swap_en), int'(e_sw));
            chk(e_tag, "reg_idx", int'(reg_idx), e_idx);
            chk(e_tag, "wait_cnt", int'(wait_cnt), e_wait);
            chk(e_dtag, "per_wdata", int'(per_wdata), int'(e_pw));
            chk(e_dtag, "rdata", int'(rdata), int'(e_rd));
        end
    end

    int seq = 0;

    task automatic req(input logic [15:0] a, input bit word, input bit wr);
        @(negedge clk);
        seq++;
        req_valid = 1'b1;
        req_addr  = a;
        req_word  = word;
        req_wr    = wr;
        req_wdata = 16'(seq * 16'h3A17 + 16'h1234);
        per_rdata = 16'(seq * 16'h5B29 + 16'h00F1);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 16'h0800;
    endtask

    initial begin
        // R12: outputs held at zero while reset is low
        repeat (2) @(negedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();
        // R1 / R2 / R3: status register and its mirrors
        eth_irq = 1'b1; req(16'h0040, 1, 0);
        eth_irq = 1'b0; req(16'h0040, 1, 0);
        eth_irq = 1'b1; req(16'h7740, 1, 0);
        req(16'h30C0, 1, 0);
        req(16'h0040, 0, 0);
        eth_irq = 1'b0; req(16'h4040, 0, 0);
        eth_irq = 1'b1; req(16'h0040, 1, 1);
        // R4 / R5 / R6 / R10: controller windows
        req(16'h0800, 1, 0); req(16'h087C, 1, 1); req(16'h0840, 1, 0);
        req(16'h0880, 1, 0); req(16'h08FC, 1, 1); req(16'h0900, 1, 0);
        req(16'h0FFC, 1, 0); req(16'h1804, 1, 0); req(16'h1804, 1, 1);
        req(16'h18C0, 1, 0); req(16'h1FFC, 1, 1);
        // R7: auxiliary windows
        req(16'h2810, 1, 0); req(16'h2810, 1, 1);
        req(16'h3810, 1, 0); req(16'h3FFC, 1, 1);
        // R8: byte accesses into peripheral windows
        req(16'h0800, 0, 0); req(16'h1880, 0, 1); req(16'h2804, 0, 0);
        // R9: reserved offsets
        req(16'h0000, 1, 0); req(16'h1000, 1, 1); req(16'h4800, 1, 0);
        req(16'h8000, 1, 0); req(16'hC040, 1, 0); req(16'h8840, 1, 1);
        // R11: gaps between requests
        idle(); req(16'h0804, 1, 0); idle(); idle();
        // sweep across the whole offset space
        for (int i = 0; i < 16'hFFFF; i += 16'h0044) begin
            eth_irq = (i % 3) == 0;
            req(16'(i), (i % 5) != 0, (i % 7) < 3);
            if ((i % 11) == 0) idle();
        end
        idle(); idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule